// File: doc/BRIEF.md
# Masked Interrupt Priority Encoder Front-End

This block sits in user logic in front of an interrupt controller that accepts a six-line encoded request bus. Nine interrupt sources are captured on their rising edges and held as pending. A bus-writable enable register lets each pending source through or blocks it. A second bus-writable register lets software retire the source it has just serviced. A priority encoder picks the highest-numbered source that is both pending and enabled. Its code is registered onto the request lines.

A build-time parameter picks one of two packings. In six-bit packing the code sits on the low lines and is the source index plus one. In five-bit packing the code sits one position higher, so the controller sees even priorities. The lowest line then carries a separate individual interrupt input that takes no part in the encoding.

Top module: `irq_prio_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_o` is 0. Reset leaves all nine enable bits at 0 (blocked) and no source pending.
- R2: A source becomes pending when `src_i` bit i is 1 in a cycle where it was 0 in the previous cycle. A bit that is already 1 when reset is released also counts. A source held high does not become pending again once it has been cleared.
- R3: A pending source stays pending until a write on the clear port has a 1 in its bit position. Clear-write bits that are 0 have no effect.
- R4: If a rising edge and a clear of the same source fall in the same cycle, the source stays pending.
- R5: A source whose enable bit is 0 is excluded from the encoding, but it stays pending. Setting the bit later exposes it. A mask write replaces all nine enable bits with `mask_wdata`.
- R6: The 4-bit code is 0 when no source is both pending and enabled. Otherwise it is the code of the highest-numbered such source.
- R7: With `PACK = PACK_SIX`, source i (0 to 8) gives code i+1 on `req_o[3:0]`, and `req_o[5:4]` is 0. With all sources active the value is 9. `indiv_irq_i` has no effect.
- R8: With `PACK = PACK_FIVE`, the code is driven on `req_o[4:1]` and `req_o[5]` is 0. Source bit i stands for source number i+1, so all sources active gives the six-bit value 18 when `indiv_irq_i` is 0.
- R9: With `PACK = PACK_FIVE`, `req_o[0]` equals `indiv_irq_i` from the previous cycle.
- R10: `req_o` reflects pending and enable state one clock after that state changes. A source edge therefore reaches `req_o` two clocks after it is applied, and a mask write reaches it one clock after the write.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 9 | Interrupt source levels, bit i is source i |
| mask_we | input | 1 | Write strobe for the enable register |
| mask_wdata | input | 9 | New enable bits, 1 lets the source through |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_wdata | input | 9 | Clear bits, 1 retires the pending source |
| indiv_irq_i | input | 1 | Individual interrupt, used only in five-bit packing |
| req_o | output | 6 | Registered encoded request to the controller |

## Verification
Directed sequences are used first. A single source is tested while blocked and then while enabled, which separates the enable gating from the pending storage. A clear aimed at a different source, and then at the right one, is tested next, which exposes a clear that is too broad. An edge and a clear on the same source in the same cycle are tested to show which of the two wins. A level held high after a clear is tested to separate edge capture from level capture.

Random source, mask, clear and individual-interrupt patterns then exercise the priority choice with many sources active at once. Both packings run side by side on the same stimulus, so a shift or a stray bit in one packing shows up against the other.

// File: rtl/irq_front_pkg.sv
// Package: shared sizes and the packing selector for the interrupt
// priority front-end. Assumes the source count fits the code width.
package irq_front_pkg;

    localparam int N_SRC  = 9;
    localparam int CODE_W = $clog2(N_SRC + 1);
    localparam int REQ_W  = 6;

    typedef enum logic {
        PACK_SIX  = 1'b0,
        PACK_FIVE = 1'b1
    } pack_e;

endpackage

// File: rtl/irq_src_capture.sv
// Module: irq_src_capture
// Detects rising edges on each source and holds them as pending until
// a clear bit retires them. An edge in the same cycle as a clear wins.
// Assumes the sources are already synchronous to clk.
module irq_src_capture #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_wdata,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] src_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr_eff;

    // Previous-cycle source levels, zero after reset so a high level counts as an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    // Edge detect and qualified clear.
    always_comb begin
        rise    = src_i & ~src_q;
        clr_eff = clr_we ? clr_wdata : '0;
    end

    // Pending set/clear per source; capture has priority over clear.
    for (genvar g = 0; g < N; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)       pend_o[g] <= 1'b0;
            else if (rise[g]) pend_o[g] <= 1'b1;
            else if (clr_eff[g]) pend_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// Bus-writable enable register; a write replaces all bits. Resets to
// all blocked. Assumes single-cycle write strobes from the bus side.
module irq_mask_reg #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_o
);

    // Hold the enable bits, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_o <= '0;
        else if (we) mask_o <= wdata;
    end

endmodule

// File: rtl/irq_prio_encode.sv
// Module: irq_prio_encode
// Combinational priority encoder: highest set input index i gives code
// i+1, no input set gives 0. Assumes N+1 fits in CODE_W bits.
module irq_prio_encode #(
    parameter int N      = 9,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      act_i,
    output logic [CODE_W-1:0] code_o
);

    // Scan upward so the highest active index is the last to assign.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (act_i[i]) code_o = CODE_W'(i + 1);
        end
    end

endmodule

// File: rtl/irq_prio_front.sv
// Module: irq_prio_front
// Top of the masked interrupt priority front-end. Captures source
// edges, gates them by the enable register, encodes the winner and
// registers it onto the request bus in the selected packing.
// Assumes all inputs are synchronous to clk and reset is synchronous.
module irq_prio_front
    import irq_front_pkg::*;
#(
    parameter pack_e PACK = PACK_SIX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_wdata,
    input  logic             indiv_irq_i,
    output logic [REQ_W-1:0] req_o
);

    localparam int UP_SIX  = REQ_W - CODE_W;
    localparam int UP_FIVE = REQ_W - CODE_W - 1;

    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  mask;
    logic [N_SRC-1:0]  active;
    logic [CODE_W-1:0] code;
    logic [REQ_W-1:0]  req_d;

    irq_src_capture #(.N(N_SRC)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .pend_o    (pend)
    );

    irq_mask_reg #(.N(N_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .wdata  (mask_wdata),
        .mask_o (mask)
    );

    // Only sources that are both pending and enabled compete.
    always_comb active = pend & mask;

    irq_prio_encode #(.N(N_SRC), .CODE_W(CODE_W)) u_encode (
        .act_i  (active),
        .code_o (code)
    );

    // Pack the code for the selected request format.
    always_comb begin
        if (PACK == PACK_FIVE) req_d = {{UP_FIVE{1'b0}}, code, indiv_irq_i};
        else                   req_d = {{UP_SIX{1'b0}}, code};
    end

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= '0;
        else        req_o <= req_d;
    end

endmodule

// File: rtl/irq_prio_front_chk.sv
// Module: irq_prio_front_chk
// Assertion checker bound to irq_prio_front; observes ports only.
module irq_prio_front_chk
    import irq_front_pkg::*;
#(
    parameter pack_e PACK = PACK_SIX
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mask_we,
    input logic [N_SRC-1:0] mask_wdata,
    input logic             indiv_irq_i,
    input logic [REQ_W-1:0] req_o
);

    logic              up_q;
    logic [CODE_W-1:0] code;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    // Extract the code field for the active packing.
    always_comb code = (PACK == PACK_FIVE) ? req_o[CODE_W:1] : req_o[CODE_W-1:0];

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (PACK == PACK_SIX) |-> (req_o[REQ_W-1:CODE_W] == '0));

    assert_top_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (PACK == PACK_FIVE) |-> (req_o[REQ_W-1] == 1'b0));

    assert_indiv_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (PACK == PACK_FIVE && up_q) |-> (req_o[0] == $past(indiv_irq_i)));

    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code <= CODE_W'(N_SRC));

    assert_mask_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && mask_wdata == '0) |=> ##1 (code == '0));

endmodule

bind irq_prio_front irq_prio_front_chk #(.PACK(PACK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .indiv_irq_i (indiv_irq_i),
    .req_o       (req_o)
);

// File: tb/irq_prio_front_bench.sv
module irq_prio_front_bench;
    import irq_front_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] src = '0;
    logic       mask_we = 1'b0;
    logic [8:0] mask_wd = '0;
    logic       clr_we = 1'b0;
    logic [8:0] clr_wd = '0;
    logic       indiv = 1'b0;
    logic [5:0] req6, req5;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_front #(.PACK(PACK_SIX)) u_irq_prio_front (
        .clk(clk), .rst_n(rst_n), .src_i(src), .mask_we(mask_we),
        .mask_wdata(mask_wd), .clr_we(clr_we), .clr_wdata(clr_wd),
        .indiv_irq_i(indiv), .req_o(req6));

    irq_prio_front #(.PACK(PACK_FIVE)) u_irq_prio_front_even (
        .clk(clk), .rst_n(rst_n), .src_i(src), .mask_we(mask_we),
        .mask_wdata(mask_wd), .clr_we(clr_we), .clr_wdata(clr_wd),
        .indiv_irq_i(indiv), .req_o(req5));

    // Reference model built from the requirements.
    logic [8:0] m_prev, m_pend, m_mask;
    logic [5:0] e6, e5;

    function automatic logic [3:0] enc(input logic [8:0] a);
        logic [3:0] c = '0;
        for (int i = 0; i < 9; i++) if (a[i]) c = 4'(i + 1);
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev <= '0; m_pend <= '0; m_mask <= '0; e6 <= '0; e5 <= '0;
        end else begin
            m_prev <= src;
            m_pend <= (m_pend & ~(clr_we ? clr_wd : 9'h0)) | (src & ~m_prev);
            if (mask_we) m_mask <= mask_wd;
            e6 <= {2'b00, enc(m_pend & m_mask)};
            e5 <= {1'b0, enc(m_pend & m_mask), indiv};
        end
    end

    task automatic check(input string tag, input logic [5:0] a6, input logic [5:0] x6,
                         input logic [5:0] a5, input logic [5:0] x5);
        n_run++;
        if (a6 !== x6 || a5 !== x5) begin
            n_fail++;
            $display("FAIL %s six: act %0d exp %0d, five: act %0d exp %0d", tag, a6, x6, a5, x5);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: act hung exp finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step();
        check("R1 in reset", req6, 6'd0, req5, 6'd0);
        rst_n = 1'b1;
        step();
        check("R1 after reset", req6, 6'd0, req5, 6'd0);

        // R5: blocked source stays pending, exposed when enabled
        src[3] = 1'b1;
        step(); step();
        check("R5 blocked", req6, 6'd0, req5, 6'd0);
        mask_we = 1'b1; mask_wd = 9'h1FF;
        step();
        mask_we = 1'b0;
        step();
        check("R5 unblocked", req6, 6'd4, req5, 6'd8);
        // R10: latency of a source edge
        src[6] = 1'b1;
        step();
        check("R10 one clock", req6, 6'd4, req5, 6'd8);
        step();
        check("R10 two clocks", req6, 6'd7, req5, 6'd14);
        // R3: wrong clear bit, then right one
        clr_we = 1'b1; clr_wd = 9'h001;
        step();
        clr_wd = 9'h040;
        step();
        clr_we = 1'b0;
        check("R3 other clear", req6, 6'd7, req5, 6'd14);
        step();
        check("R3 cleared", req6, 6'd4, req5, 6'd8);
        // R2: level held high is not recaptured
        clr_we = 1'b1; clr_wd = 9'h008;
        step();
        clr_we = 1'b0;
        step(); step();
        check("R2 no recapture", req6, 6'd0, req5, 6'd0);
        // R4: edge and clear together
        src[5] = 1'b1; clr_we = 1'b1; clr_wd = 9'h020;
        step();
        clr_we = 1'b0;
        step();
        check("R4 capture wins", req6, 6'd6, req5, 6'd12);
        // R6/R7/R8: all sources
        src = '0;
        step();
        src = 9'h1FF;
        step(); step();
        check("R7 R8 all pending", req6, 6'd9, req5, 6'd18);
        // R9: individual line
        indiv = 1'b1;
        step();
        check("R9 indiv", req6, 6'd9, req5, 6'd19);
        indiv = 1'b0;
        // R6: clear everything, none pending
        clr_we = 1'b1; clr_wd = 9'h1FF;
        step();
        clr_we = 1'b0;
        step();
        check("R6 none", req6, 6'd0, req5, 6'd0);
        check("R6 model agree", req6, e6, req5, e5);

        // Random phase against the model
        for (int k = 0; k < 3000; k++) begin
            src     = 9'($urandom);
            mask_we = ($urandom % 4) == 0;
            mask_wd = 9'($urandom);
            clr_we  = ($urandom % 3) == 0;
            clr_wd  = 9'($urandom);
            indiv   = 1'($urandom);
            step();
            check("R6 R7 R8 R9 random", req6, e6, req5, e5);
        end
        finish_run();
    end

endmodule